// File: doc/BRIEF.md
# Accumulator ALU Status Flags

This block is the arithmetic half of an 8-bit accumulator datapath together with its status byte. It adds or subtracts a second operand to or from the accumulator, with or without a carry or borrow input. It returns the 8-bit result combinationally. On the clock edge of a strobed operation it records carry, auxiliary (half) carry and signed overflow in a status register. Software may load the status byte directly. Doing so also sets the two register-bank select bits, a general-purpose flag and a user flag, which arithmetic never touches.

Bit 0 of the status byte is not stored. It is the odd parity of the accumulator input, recomputed at all times, so it tracks the accumulator whether or not an operation or a write takes place. The bank select bits are also brought out on their own port for the register-file address logic.

The status byte is laid out from bit 7 down to bit 0 as follows:
- bit 7: carry/borrow
- bit 6: auxiliary carry/borrow
- bit 5: general flag
- bit 4: bank select high
- bit 3: bank select low
- bit 2: overflow
- bit 1: user flag
- bit 0: parity

Top module: `acc_flag_alu`

## Requirements
- R1: While `rst` is high at a rising edge, status bits 7..1 are cleared, so after reset `status_o` equals {7'b0, parity of `acc_i`} and `bank_o` is 0.
- R2: `op_i` selects the operation: 2'b00 gives the sum acc+operand and ignores `carry_i`; 2'b01 gives acc+operand+`carry_i`; 2'b10 gives acc-operand-`carry_i`. `result_o` is the low 8 bits of the chosen operation, available in the same cycle.
- R3: On a rising edge with `go_i` high and a valid operation, status bit 7 is loaded with the carry out of bit 7 for an addition. For the subtraction it is loaded with the borrow out of bit 7.
- R4: On the same condition, status bit 6 is loaded with the carry out of bit 3 for an addition. For the subtraction it is loaded with the borrow out of bit 3.
- R5: On the same condition, status bit 2 is loaded with 1 exactly when the operation, read as two's-complement, overflows 8 bits.
- R6: `status_o[0]` is 1 exactly when `acc_i` holds an odd number of ones. It follows `acc_i` combinationally, whatever writes or operations occur.
- R7: A rising edge with `wr_i` high loads status bits 7..1 from `wr_data_i[7:1]`. `wr_data_i[0]` has no effect.
- R8: An operation leaves status bits 5, 4, 3 and 1 unchanged.
- R9: When `wr_i` and `go_i` are high at the same edge, the write wins and the operation changes no status bit.
- R10: `bank_o` equals status bits {4,3}.
- R11: `op_i` = 2'b11 is a no-operation: `result_o` equals `acc_i` and a strobe on `go_i` leaves bits 7..1 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 8 | Accumulator value, first operand and parity source |
| opnd_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry-in for add-with-carry, borrow-in for subtract |
| op_i | input | 2 | Operation select (see R2, R11) |
| go_i | input | 1 | Commit the operation's flags at this edge |
| wr_i | input | 1 | Software write of the status byte |
| wr_data_i | input | 8 | Status byte to write; bit 0 ignored |
| result_o | output | 8 | Operation result |
| status_o | output | 8 | Status byte |
| bank_o | output | 2 | Active register bank |

## Verification
The hardest cases to reach from the ports are the ones where the flags disagree with each other. Examples are a borrow out of bit 3 without a borrow out of bit 7, and a signed overflow with no unsigned carry. A write colliding with an operation on the same edge is also hard to reach. The stimulus table picks operand pairs that split each flag from the others, for both addition and subtraction. Directed steps then preload the status byte with all-ones or chosen patterns. This shows that an operation preserves the software bits, that a colliding write takes over, and that the parity bit ignores written data.

// File: rtl/acc_flag_alu_pkg.sv
package acc_flag_alu_pkg;

    localparam int DATA_W   = 8;
    localparam int STAT_W   = 8;
    localparam int HALF_POS = 4;

    // status byte bit positions
    localparam int CY_BIT = 7;
    localparam int AC_BIT = 6;
    localparam int F0_BIT = 5;
    localparam int BK_HI  = 4;
    localparam int BK_LO  = 3;
    localparam int OV_BIT = 2;
    localparam int UF_BIT = 1;
    localparam int P_BIT  = 0;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_ADDC = 2'b01,
        OP_SUBB = 2'b10,
        OP_NONE = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } arith_flags_t;

    function automatic logic op_is_sub(alu_op_e op);
        return op == OP_SUBB;
    endfunction

    function automatic logic op_uses_carry(alu_op_e op);
        return (op == OP_ADDC) || (op == OP_SUBB);
    endfunction

endpackage

// File: rtl/acc_flag_alu_adder.sv
module acc_flag_alu_adder
    import acc_flag_alu_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AUX = HALF_POS
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          carry_i,
    input  alu_op_e       op_i,
    output logic [DW-1:0] sum_o,
    output arith_flags_t  flags_o
);

    localparam int MW = DW - 1 - AUX;

    logic          sub;
    logic          cin;
    logic [DW-1:0] bx;
    logic [AUX:0]  lo;
    logic [MW:0]   mid;
    logic [1:0]    tp;

    always_comb begin
        sub = op_is_sub(op_i);
        bx  = sub ? ~b_i : b_i;
        if (op_uses_carry(op_i)) begin
            cin = sub ? ~carry_i : carry_i;
        end else begin
            cin = sub;
        end
        // low segment up to the half-carry point
        lo  = {1'b0, a_i[AUX-1:0]} + {1'b0, bx[AUX-1:0]} + {{AUX{1'b0}}, cin};
        // middle segment up to the sign bit
        mid = {1'b0, a_i[DW-2:AUX]} + {1'b0, bx[DW-2:AUX]} + {{MW{1'b0}}, lo[AUX]};
        // sign bit alone, so carry in and carry out are both visible
        tp  = {1'b0, a_i[DW-1]} + {1'b0, bx[DW-1]} + {1'b0, mid[MW]};
        sum_o      = {tp[0], mid[MW-1:0], lo[AUX-1:0]};
        flags_o.cy = tp[1] ^ sub;
        flags_o.ac = lo[AUX] ^ sub;
        flags_o.ov = tp[1] ^ mid[MW];
    end

endmodule

// File: rtl/acc_flag_alu_parity.sv
module acc_flag_alu_parity #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data_i,
    output logic          odd_o
);

    logic [DW:0] chain;

    assign chain[0] = 1'b0;

    for (genvar gi = 0; gi < DW; gi++) begin : g_xor
        assign chain[gi+1] = chain[gi] ^ data_i[gi];
    end

    assign odd_o = chain[DW];

endmodule

// File: rtl/acc_flag_alu_status.sv
module acc_flag_alu_status
    import acc_flag_alu_pkg::*;
#(
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en_i,
    input  logic [SW-1:0] wr_data_i,
    input  logic          upd_en_i,
    input  arith_flags_t  flags_i,
    input  logic          parity_i,
    output logic [SW-1:0] status_o
);

    logic [SW-1:1] st_q;
    logic          unused_wr_p;

    assign unused_wr_p = wr_data_i[P_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (wr_en_i) begin
            st_q <= wr_data_i[SW-1:1];
        end else if (upd_en_i) begin
            st_q[CY_BIT] <= flags_i.cy;
            st_q[AC_BIT] <= flags_i.ac;
            st_q[OV_BIT] <= flags_i.ov;
        end
    end

    assign status_o = {st_q, parity_i};

endmodule

// File: rtl/acc_flag_alu.sv
module acc_flag_alu
    import acc_flag_alu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opnd_i,
    input  logic          carry_i,
    input  logic [1:0]    op_i,
    input  logic          go_i,
    input  logic          wr_i,
    input  logic [SW-1:0] wr_data_i,
    output logic [DW-1:0] result_o,
    output logic [SW-1:0] status_o,
    output logic [1:0]    bank_o
);

    alu_op_e      op;
    logic [DW-1:0] sum;
    arith_flags_t flags;
    logic         par;
    logic         upd;

    assign op = alu_op_e'(op_i);

    acc_flag_alu_adder #(.DW(DW), .AUX(HALF_POS)) u_adder (
        .a_i     (acc_i),
        .b_i     (opnd_i),
        .carry_i (carry_i),
        .op_i    (op),
        .sum_o   (sum),
        .flags_o (flags)
    );

    acc_flag_alu_parity #(.DW(DW)) u_parity (
        .data_i (acc_i),
        .odd_o  (par)
    );

    assign upd = go_i && (op != OP_NONE);

    acc_flag_alu_status #(.SW(SW)) u_status (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_i),
        .wr_data_i (wr_data_i),
        .upd_en_i  (upd),
        .flags_i   (flags),
        .parity_i  (par),
        .status_o  (status_o)
    );

    assign result_o = (op == OP_NONE) ? acc_i : sum;
    assign bank_o   = status_o[BK_HI:BK_LO];

endmodule

// File: rtl/acc_flag_alu_chk.sv
module acc_flag_alu_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] acc_i,
    input logic [7:0] opnd_i,
    input logic [1:0] op_i,
    input logic       go_i,
    input logic       wr_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] result_o,
    input logic [7:0] status_o,
    input logic [1:0] bank_o
);

    logic [8:0] add9;
    assign add9 = {1'b0, acc_i} + {1'b0, opnd_i};

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> status_o[7:1] == 7'd0);

    // R2
    add_result_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == 2'b00 |-> result_o == add9[7:0]);

    // R3
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        go_i && !wr_i && op_i == 2'b00 |=> status_o[7] == $past(add9[8]));

    // R6
    parity_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[0] == ($countones(acc_i) % 2 == 1));

    // R7 and R9: the write wins whether or not go_i is high
    sw_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> status_o[7:1] == $past(wr_data_i[7:1]));

    // R8
    keep_sw_bits_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(status_o[5:3]) && $stable(status_o[1]));

    // R10
    bank_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> bank_o == $past(wr_data_i[4:3]));

    // R11
    idle_op_chk: assert property (@(posedge clk) disable iff (rst)
        go_i && !wr_i && op_i == 2'b11 |=> $stable(status_o[7:1]));

endmodule

bind acc_flag_alu acc_flag_alu_chk u_chk (.*);

// File: tb/acc_flag_alu_test.sv
module acc_flag_alu_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;
    localparam int WATCHDOG = 5000;

    // {op, a, b, cin, result, cy, ac, ov}
    localparam logic [29:0] VEC [NVEC] = '{
        {2'b00, 8'h3A, 8'h16, 1'b0, 8'h50, 3'b010},
        {2'b00, 8'h7F, 8'h01, 1'b0, 8'h80, 3'b011},
        {2'b00, 8'hFF, 8'h01, 1'b0, 8'h00, 3'b110},
        {2'b00, 8'h80, 8'h80, 1'b0, 8'h00, 3'b101},
        {2'b00, 8'h0F, 8'h00, 1'b1, 8'h0F, 3'b000},
        {2'b01, 8'h12, 8'h34, 1'b1, 8'h47, 3'b000},
        {2'b01, 8'h12, 8'h34, 1'b0, 8'h46, 3'b000},
        {2'b01, 8'h0F, 8'h00, 1'b1, 8'h10, 3'b010},
        {2'b10, 8'h50, 8'h20, 1'b0, 8'h30, 3'b000},
        {2'b10, 8'h10, 8'h01, 1'b0, 8'h0F, 3'b010},
        {2'b10, 8'h00, 8'h01, 1'b0, 8'hFF, 3'b110},
        {2'b10, 8'h80, 8'h01, 1'b0, 8'h7F, 3'b011},
        {2'b10, 8'h7F, 8'hFF, 1'b0, 8'h80, 3'b101},
        {2'b10, 8'h05, 8'h05, 1'b1, 8'hFF, 3'b110},
        {2'b10, 8'h05, 8'h04, 1'b1, 8'h00, 3'b000}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic       carry_i = 1'b0;
    logic [1:0] op_i = '0;
    logic       go_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] result_o;
    logic [7:0] status_o;
    logic [1:0] bank_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_flag_alu uut (
        .clk       (clk),
        .rst       (rst),
        .acc_i     (acc_i),
        .opnd_i    (opnd_i),
        .carry_i   (carry_i),
        .op_i      (op_i),
        .go_i      (go_i),
        .wr_i      (wr_i),
        .wr_data_i (wr_data_i),
        .result_o  (result_o),
        .status_o  (status_o),
        .bank_o    (bank_o)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic odd(logic [7:0] v);
        return ($countones(v) % 2) == 1;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 status after reset", status_o, 8'h00);
        check("R1 bank after reset", {6'd0, bank_o}, 8'h00);

        // R6 parity follows the accumulator with no clock edge
        acc_i = 8'h01; #1 check("R6 parity 01", {7'd0, status_o[0]}, 8'h01);
        acc_i = 8'h03; #1 check("R6 parity 03", {7'd0, status_o[0]}, 8'h00);
        acc_i = 8'h80; #1 check("R6 parity 80", {7'd0, status_o[0]}, 8'h01);
        acc_i = 8'hFF; #1 check("R6 parity FF", {7'd0, status_o[0]}, 8'h00);
        @(negedge clk);

        // R2..R5 table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [29:0] v;
            v = VEC[i];
            op_i    = v[29:28];
            acc_i   = v[27:20];
            opnd_i  = v[19:12];
            carry_i = v[11];
            go_i    = 1'b1;
            #1;
            check("R2 result", result_o, v[10:3]);
            tick();
            go_i = 1'b0;
            check("R3 carry flag", {7'd0, status_o[7]}, {7'd0, v[2]});
            check("R4 aux flag", {7'd0, status_o[6]}, {7'd0, v[1]});
            check("R5 overflow flag", {7'd0, status_o[2]}, {7'd0, v[0]});
            check("R6 parity in table", {7'd0, status_o[0]}, {7'd0, odd(acc_i)});
        end

        // R7 write all ones; bit 0 of the data has no effect
        acc_i = 8'h00;
        wr_i = 1'b1; wr_data_i = 8'hFF;
        tick();
        wr_i = 1'b0;
        check("R7 write FF", status_o, 8'hFE);
        check("R10 bank after FF", {6'd0, bank_o}, 8'h03);

        // R8 an add keeps bits 5,4,3,1
        op_i = 2'b00; acc_i = 8'h01; opnd_i = 8'h01; carry_i = 1'b0; go_i = 1'b1;
        tick();
        go_i = 1'b0;
        check("R8 sw bits kept", status_o, 8'h3B);

        // R9 write collides with a carrying add
        op_i = 2'b00; acc_i = 8'hFF; opnd_i = 8'h01; go_i = 1'b1;
        wr_i = 1'b1; wr_data_i = 8'h10;
        tick();
        go_i = 1'b0; wr_i = 1'b0;
        check("R9 write wins", status_o, 8'h10);
        check("R10 bank 2", {6'd0, bank_o}, 8'h02);

        // R11 reserved op
        wr_i = 1'b1; wr_data_i = 8'hC4;
        tick();
        wr_i = 1'b0;
        op_i = 2'b11; acc_i = 8'h55; opnd_i = 8'h22; go_i = 1'b1;
        #1 check("R11 result is acc", result_o, 8'h55);
        tick();
        go_i = 1'b0;
        check("R11 status unchanged", status_o, 8'hC4);

        // R1 reset again clears written bits
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R1 status after second reset", status_o, {7'd0, odd(acc_i)});

        finish_run();
    end

endmodule